// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Port

This block is one general-purpose I/O port of eight pins, configured and observed through a small register bus. Each pin can be an input or an output under software control, or it can be handed over to a peripheral, which then drives the pin's output value and output enable directly. A pull resistor can be enabled on each pin. The output-data bit of that pin then chooses whether the resistor pulls up or pulls down. A separate bit per pin selects reduced or full drive strength.

Pin levels pass through a two-flop synchronizer before software reads them. The synchronized levels also go to the peripherals. The port drives five control vectors towards the pad ring: output enable, output value, pull enable, pull direction and drive strength. Register writes take effect at the clock edge on which `bus_we_i` is sampled. Reads are combinational on the address.

Top module: `gpio_port`

## Requirements
- R1: After reset every writable register holds 0. Every pin is then an input, with no pull, reduced drive (`pad_drive_o`=0) and software I/O selected.
- R2: The direction register is at offset 2. Bit value 1 makes the pin an output (`pad_oe_o`=1) and 0 makes it an input, when the pin is in software mode.
- R3: The output register is at offset 1. In software mode `pad_out_o` equals the output register bit.
- R4: The input register is at offset 0 and returns the pin level as it was two clock edges earlier (two-flop synchronizer). Writes to offset 0 change no register and no pad output.
- R5: The function-select register is at offset 5. Where its bit is 1, `per_oe_i` and `per_out_i` replace the direction and output register bits on the pad.
- R6: The resistor-enable register is at offset 3. Where its bit is 1 and the pin is not driven, `pad_pull_en_o` is 1 and `pad_pull_up_o` equals the output register bit (1 selects pull-up, 0 selects pull-down).
- R7: A pin that is driven (`pad_oe_o`=1) has `pad_pull_en_o`=0 and `pad_pull_up_o`=0, whatever its resistor-enable bit holds.
- R8: The drive-strength register is at offset 4. `pad_drive_o` equals its bit (0 selects reduced drive, 1 selects full drive).
- R9: Offsets 6 and 7 read as 0, and writes to them change no register.
- R10: Each writable register reads back at its offset the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| pin_i | input | 8 | Pad input levels |
| per_out_i | input | 8 | Peripheral output values |
| per_oe_i | input | 8 | Peripheral output enables |
| per_in_o | output | 8 | Synchronized pin levels to peripherals |
| pad_oe_o | output | 8 | Pad output enable |
| pad_out_o | output | 8 | Pad output value |
| pad_pull_en_o | output | 8 | Pad pull resistor enable |
| pad_pull_up_o | output | 8 | Pad pull direction, 1 for up |
| pad_drive_o | output | 8 | Pad drive strength, 1 for full |

## Verification
Every register feeds a pad output combinationally. A wrong direction, output, select, resistor or drive bit therefore shows on the pad vectors in the same cycle as the write that left it wrong. Register readback exposes the same state again on the bus. A synchronizer with the wrong depth shifts the first cycle in which the input register holds a new pin level by one edge. The bench samples in the cycle between the two edges, so that shift is caught. A write decode that reaches offset 0, 6 or 7 corrupts a register, and the pads or the readback show it right after the write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_IN   = 3'd0,
    OFS_OUT  = 3'd1,
    OFS_DIR  = 3'd2,
    OFS_REN  = 3'd3,
    OFS_DS   = 3'd4,
    OFS_SEL  = 3'd5
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // Output follows the input with a latency of two edges, once two cycles have passed since reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_sync_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STAGES == 2 && age_q == 2'd2) |-> q_o == $past(d_i, 2))
    else $error("sync latency");
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] in_sync_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] ren_o,
  output logic [NUM_PINS-1:0] ds_o,
  output logic [NUM_PINS-1:0] sel_o
);
  logic [NUM_PINS-1:0] out_q, dir_q, ren_q, ds_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      ren_q <= '0;
      ds_q  <= '0;
      sel_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_OUT: out_q <= wdata_i;
        OFS_DIR: dir_q <= wdata_i;
        OFS_REN: ren_q <= wdata_i;
        OFS_DS:  ds_q  <= wdata_i;
        OFS_SEL: sel_q <= wdata_i;
        default: ;  // input register and holes are not writable
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFS_IN:  rdata_o = in_sync_i;
      OFS_OUT: rdata_o = out_q;
      OFS_DIR: rdata_o = dir_q;
      OFS_REN: rdata_o = ren_q;
      OFS_DS:  rdata_o = ds_q;
      OFS_SEL: rdata_o = sel_q;
      default: rdata_o = '0;
    endcase
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
  assign ren_o = ren_q;
  assign ds_o  = ds_q;
  assign sel_o = sel_q;

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DIR) |=> dir_q == $past(wdata_i))
    else $error("dir write");

  p_out_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_OUT) |=> out_q == $past(wdata_i))
    else $error("out write");

  p_in_write_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_IN) |=> $stable({out_q, dir_q, ren_q, ds_q, sel_q}))
    else $error("write to input register");

  p_hole_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > OFS_SEL) |=> $stable({out_q, dir_q, ren_q, ds_q, sel_q}))
    else $error("write to hole");
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] ren_i,
  input  logic [NUM_PINS-1:0] ds_i,
  input  logic [NUM_PINS-1:0] sel_i,
  input  logic [NUM_PINS-1:0] per_out_i,
  input  logic [NUM_PINS-1:0] per_oe_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pull_en_o,
  output logic [NUM_PINS-1:0] pad_pull_up_o,
  output logic [NUM_PINS-1:0] pad_drive_o
);
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic oe;
    assign oe               = sel_i[k] ? per_oe_i[k]  : dir_i[k];
    assign pad_oe_o[k]      = oe;
    assign pad_out_o[k]     = sel_i[k] ? per_out_i[k] : out_i[k];
    // pull only on an undriven pin; output bit picks the rail
    assign pad_pull_en_o[k] = ren_i[k] & ~oe;
    assign pad_pull_up_o[k] = ren_i[k] & ~oe & out_i[k];
    assign pad_drive_o[k]   = ds_i[k];
  end

  always_comb begin
    a_no_pull_on_driven_r7: assert ((pad_oe_o & (pad_pull_en_o | pad_pull_up_o)) == '0)
      else $error("pull on driven pin");
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] per_out_i,
  input  logic [NUM_PINS-1:0] per_oe_i,
  output logic [NUM_PINS-1:0] per_in_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pull_en_o,
  output logic [NUM_PINS-1:0] pad_pull_up_o,
  output logic [NUM_PINS-1:0] pad_drive_o
);
  logic [NUM_PINS-1:0] in_sync, out_r, dir_r, ren_r, ds_r, sel_r;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (in_sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .in_sync_i(in_sync),
    .out_o    (out_r),
    .dir_o    (dir_r),
    .ren_o    (ren_r),
    .ds_o     (ds_r),
    .sel_o    (sel_r)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .out_i        (out_r),
    .dir_i        (dir_r),
    .ren_i        (ren_r),
    .ds_i         (ds_r),
    .sel_i        (sel_r),
    .per_out_i    (per_out_i),
    .per_oe_i     (per_oe_i),
    .pad_oe_o     (pad_oe_o),
    .pad_out_o    (pad_out_o),
    .pad_pull_en_o(pad_pull_en_o),
    .pad_pull_up_o(pad_pull_up_o),
    .pad_drive_o  (pad_drive_o)
  );

  assign per_in_o = in_sync;

  // A drive-strength write shows on the pads on the next cycle
  p_drive_follows_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_DS) |=> pad_drive_o == $past(bus_wdata_i))
    else $error("drive strength");
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin = '0, per_out = '0, per_oe = '0;
  logic [7:0] per_in, oe, pout, pe, pu, drv;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin),
    .per_out_i(per_out), .per_oe_i(per_oe), .per_in_o(per_in),
    .pad_oe_o(oe), .pad_out_o(pout), .pad_pull_en_o(pe),
    .pad_pull_up_o(pu), .pad_drive_o(drv)
  );

  // {dir, out, ren, ds, sel, per_oe, per_out, exp_oe, exp_out, exp_pe, exp_pu, exp_drv}
  localparam logic [95:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'h0F, 8'hFF, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF, 8'h0F, 8'hF0},
    {8'h0F, 8'h33, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h33, 8'hF0, 8'h30, 8'h00},
    {8'hFF, 8'h00, 8'h0F, 8'hFF, 8'hFF, 8'h0F, 8'h55, 8'h0F, 8'h55, 8'h00, 8'h00, 8'hFF},
    {8'h00, 8'hC3, 8'hFF, 8'h3C, 8'hF0, 8'h30, 8'hA0, 8'h30, 8'hA3, 8'hCF, 8'hC3, 8'h3C},
    {8'hAA, 8'hFF, 8'h55, 8'h55, 8'h00, 8'hFF, 8'h00, 8'hAA, 8'hFF, 8'h55, 8'h55, 8'h55}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic pads_chk(input string req, input logic [7:0] e_oe, input logic [7:0] e_out,
                          input logic [7:0] e_pe, input logic [7:0] e_pu, input logic [7:0] e_drv);
    chk({req, " oe"}, oe, e_oe);
    chk({req, " out"}, pout, e_out);
    chk({req, " pull_en"}, pe, e_pe);
    chk({req, " pull_up"}, pu, e_pu);
    chk({req, " drive"}, drv, e_drv);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    pads_chk("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int a = 1; a < 6; a++) rd_chk("R1 reg", 3'(a), 8'h00);

    // Vector walk: R2 R3 R5 R6 R7 R8 R10
    for (int i = 0; i < 6; i++) begin
      logic [95:0] v;
      v = VEC[i];
      wr(3'd2, v[95:88]);
      wr(3'd1, v[87:80]);
      wr(3'd3, v[79:72]);
      wr(3'd4, v[71:64]);
      wr(3'd5, v[63:56]);
      per_oe = v[55:48];
      per_out = v[47:40];
      #1;
      pads_chk("R2/R3/R5/R6/R7/R8", v[39:32], v[31:24], v[23:16], v[15:8], v[7:0]);
      rd_chk("R10 dir", 3'd2, v[95:88]);
      rd_chk("R10 out", 3'd1, v[87:80]);
      rd_chk("R10 ren", 3'd3, v[79:72]);
      rd_chk("R10 ds", 3'd4, v[71:64]);
      rd_chk("R10 sel", 3'd5, v[63:56]);
    end

    // R4: two-edge synchronizer latency
    @(negedge clk);
    pin = 8'h00;
    repeat (3) @(negedge clk);
    pin = 8'h5A;
    @(negedge clk);
    rd_chk("R4 after one edge", 3'd0, 8'h00);
    @(negedge clk);
    rd_chk("R4 after two edges", 3'd0, 8'h5A);
    chk("R4 per_in", per_in, 8'h5A);

    // R4: write to input register ignored (state from last vector)
    wr(3'd0, 8'h00);
    #1;
    pads_chk("R4 write ignored", 8'hAA, 8'hFF, 8'h55, 8'h55, 8'h55);
    rd_chk("R4 in still pin", 3'd0, 8'h5A);

    // R9: holes read zero and ignore writes
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'h00);
    rd_chk("R9 read 6", 3'd6, 8'h00);
    rd_chk("R9 read 7", 3'd7, 8'h00);
    rd_chk("R9 dir kept", 3'd2, 8'hAA);
    rd_chk("R9 ds kept", 3'd4, 8'h55);
    pads_chk("R9 pads kept", 8'hAA, 8'hFF, 8'h55, 8'h55, 8'h55);

    // R7: pull-down selection on undriven pins, suppressed on driven ones
    wr(3'd2, 8'hF0);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'hFF);
    #1;
    chk("R6 pull-down en", pe, 8'h0F);
    chk("R6 pull-down dir", pu, 8'h00);
    chk("R7 driven no pull", pe & oe, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule